// File: doc/BRIEF.md
# Pin Port with Change-Flag Interrupts

This block is a memory-mapped general-purpose pin port. The number of pins is set by a parameter, up to 32. Software reaches it through a single-cycle 32-bit register port. Each pin has a direction bit, which selects between driving an output level and sampling an input. It also has a data bit, which holds the level driven while the pin is an output.

Every pin configured as an input is watched by an edge detector. Its input first passes through a two-flop synchronizer. Any rising or falling transition latches a per-pin change flag, and software acknowledges that flag by writing a one to it. The flags are gated by a per-pin enable mask and collapsed into one level interrupt line, which a parent interrupt controller can share.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous reset, the direction, data, enable and change registers are zero. All pins are therefore inputs, `pin_oe` and `pin_out` are zero and `irq_out` is low.
- R2: Bit i of the direction register (byte offset 0x00) set to 1 makes pin i an output: `pin_oe[i]` is 1 and `pin_out[i]` follows bit i of the data register (offset 0x04). Setting the direction bit to 0 makes pin i an input and releases `pin_oe[i]`.
- R3: A read of offset 0x04 returns, per pin, the written data bit if the pin is an output and the synchronized pin level if it is an input.
- R4: On an input pin, both a rising and a falling transition of `pin_in` set that pin's bit in the change register (offset 0x0C). The flag sets on the third rising clock edge after the input changes. Transitions on output pins set no flag.
- R5: Writing offset 0x0C clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R6: When a new edge and a write-1 clear of the same flag land on the same clock edge, the flag stays set.
- R7: `irq_out` is a registered level. It is high one cycle after any bit of (change AND enable) is set, where the enable register is at offset 0x08 and 1 means unmasked. It is low one cycle after no such bit remains.
- R8: Offset 0x10 stores a mask value and reads it back. Offset 0x14 always reads the constant 0x3, the code for both-edge mode, and ignores writes.
- R9: Bits at or above the configured pin count read as zero in every register and are ignored on writes.
- R10: Read data appears on `bus_rdata` one cycle after the read request. Offsets outside the six defined registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad levels, asynchronous |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables, 1 = drive |
| irq_out | output | 1 | Shared level interrupt |

## Verification
The bench aims at the cycle where an edge and a write-1 acknowledge meet on the same flag. A design that gave the clear priority would lose that event, so the flag would read back as zero and no interrupt would follow. It also toggles pins while they are outputs, where a detector not gated by direction would raise flags that should never appear. It writes zero bits to the change register, where a plain overwrite would wipe flags that are still pending. It runs with fewer pins than the bus width, so a missing mask would show stray high bits in readback. Random register writes interleaved with pin activity are compared against a bench model of the flags, the enables and the interrupt level.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;
  // Byte offsets decoded by the register bank
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CHG   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WMASK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 5'h14;
  // Trigger mode code: both edges
  localparam logic [BUS_W-1:0] TYPE_BOTH_EDGES = 32'h0000_0003;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] level_prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_prev <= '0;
    else     level_prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/gpio_flags.sv
module gpio_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] edge_hit,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_eff;

  always_comb clr_eff = clr_we ? clr_bits : '0;

  // A fresh edge overrides an acknowledge on the same bit
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | edge_hit;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (rst)
      edge_hit[i] |=> flags[i]);
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (edge_hit[i] && clr_we && clr_bits[i]) |=> flags[i]);
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_bits[i] && !edge_hit[i]) |=> !flags[i]);
    p_zero_keeps_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_we && !clr_bits[i] && !edge_hit[i]) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [W-1:0]      pin_level,
  input  logic [W-1:0]      flags,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      ien_q,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [W-1:0]     wmask_q;
  logic [W-1:0]     wd;
  logic             wr, rd;
  logic [W-1:0]     rd_sel;
  logic             rd_hit;
  logic [BUS_W-1:0] rd_word;

  assign wd = bus_wdata[W-1:0];
  assign wr = bus_sel &  bus_we;
  assign rd = bus_sel & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      data_q  <= '0;
      ien_q   <= '0;
      wmask_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_DIR:   dir_q   <= wd;
        OFS_DATA:  data_q  <= wd;
        OFS_IEN:   ien_q   <= wd;
        OFS_WMASK: wmask_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    case (bus_addr)
      OFS_DIR:   rd_sel = dir_q;
      OFS_DATA:  rd_sel = (dir_q & data_q) | (~dir_q & pin_level);
      OFS_IEN:   rd_sel = ien_q;
      OFS_CHG:   rd_sel = flags;
      OFS_WMASK: rd_sel = wmask_q;
      default: begin rd_sel = '0; rd_hit = 1'b0; end
    endcase
    rd_word = '0;
    if (bus_addr == OFS_TYPE) rd_word = TYPE_BOTH_EDGES;
    else if (rd_hit)          rd_word[W-1:0] = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_word;
  end

  p_type_const_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == OFS_TYPE) |=> (bus_rdata == TYPE_BOTH_EDGES));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFS_DIR) |=> (dir_q == $past(wd)));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  logic [NPINS-1:0] lvl, lvl_prev, edge_hit, flags;
  logic [NPINS-1:0] dir_q, data_q, ien_q;
  logic             clr_we;
  logic             pend_any;

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in),
    .level(lvl), .level_prev(lvl_prev)
  );

  assign edge_hit = (lvl ^ lvl_prev) & ~dir_q;
  assign clr_we   = bus_sel & bus_we & (bus_addr == OFS_CHG);

  gpio_flags #(.W(NPINS)) u_flags (
    .clk(clk), .rst(rst), .edge_hit(edge_hit),
    .clr_we(clr_we), .clr_bits(bus_wdata[NPINS-1:0]), .flags(flags)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_level(lvl),
    .flags(flags), .dir_q(dir_q), .data_q(data_q), .ien_q(ien_q),
    .bus_rdata(bus_rdata)
  );

  assign pend_any = |(flags & ien_q);

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= pend_any;
  end

  assign pin_oe  = dir_q;
  assign pin_out = data_q;

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    pend_any |=> irq_out);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !pend_any |=> !irq_out);
  p_out_no_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (dir_q == '1) |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb_top;
  localparam int N = 24;
  localparam logic [31:0] MASK = (32'h1 << N) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq_out;

  int total = 0, bad = 0;
  logic [31:0] dir_m = 0, dat_m = 0, en_m = 0, chg_m = 0, wm_m = 0, pins_m = 0;

  always #5 clk = ~clk;

  gpio_edge_port #(.NPINS(N)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    case (a)
      5'h00: dir_m = d & MASK;
      5'h04: dat_m = d & MASK;
      5'h08: en_m  = d & MASK;
      5'h0C: chg_m = chg_m & ~d;
      5'h10: wm_m  = d & MASK;
      default: ;
    endcase
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic set_pins(logic [31:0] p);
    @(negedge clk);
    chg_m = chg_m | ((pins_m ^ p) & ~dir_m & MASK);
    pins_m = p & MASK;
    pin_in = pins_m[N-1:0];
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] data_exp();
    return ((dir_m & dat_m) | (~dir_m & pins_m)) & MASK;
  endfunction

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(5'h00, v); check({tag, " R2 dir"}, v, dir_m);
    rd(5'h04, v); check({tag, " R3 data"}, v, data_exp());
    rd(5'h08, v); check({tag, " R7 ien"}, v, en_m);
    rd(5'h0C, v); check({tag, " R4/R5 chg"}, v, chg_m);
    rd(5'h10, v); check({tag, " R8 wmask"}, v, wm_m);
    check({tag, " R2 oe"}, {8'h0, pin_oe}, dir_m);
    check({tag, " R2 out"}, {8'h0, pin_out}, dat_m);
    check({tag, " R7 irq"}, {31'h0, irq_out}, {31'h0, |(chg_m & en_m)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 oe", {8'h0, pin_oe}, 0);
    check("R1 irq", {31'h0, irq_out}, 0);
    check_all("R1");
    // R8 type constant and write ignored; R10 unmapped reads zero
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); check("R8 type", v, 32'h3);
    rd(5'h18, v); check("R10 unmapped", v, 0);
    rd(5'h1C, v); check("R10 unmapped2", v, 0);
    // R9 upper bits ignored
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); check("R9 wmask upper", v, MASK);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R9 data inputs", v, 0);
    // R4 rising and falling edges on inputs
    wr(5'h08, 32'h1);
    set_pins(32'h1);
    check_all("R4 rise");
    wr(5'h0C, 32'h1);
    check_all("R5 ack");
    set_pins(32'h0);
    check_all("R4 fall");
    // R5 write zero keeps flag
    wr(5'h0C, 32'h0);
    check_all("R5 zero");
    wr(5'h0C, 32'h1);
    // R4 output pins raise no flag
    wr(5'h00, 32'h00F0);
    set_pins(32'h00F0);
    check_all("R4 outpin");
    // R6 edge and acknowledge on the same clock edge
    @(negedge clk);
    pin_in[2] = 1'b1;
    pins_m[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 5'h0C; bus_wdata = 32'h4;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    chg_m[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'h0C, v); check("R6 edge wins", v & 32'h4, 32'h4);
    wr(5'h08, 32'h4);
    check_all("R6 irq");
    // random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) set_pins($urandom());
      else begin
        logic [4:0] a;
        a = 5'($urandom_range(0, 5) * 4);
        wr(a, $urandom());
      end
      repeat (2) @(negedge clk);
      if (k % 10 == 0) check_all("R3 rand");
      else check("R7 irq rand", {31'h0, irq_out}, {31'h0, |(chg_m & en_m)});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule